// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block keeps the general-purpose event state of a power-management controller. It decodes a fixed 4-byte I/O window at 0xAFE0, with no relocation. The lower half of the window holds event status bytes and the upper half holds the matching enable bytes. Hardware event sources, such as hotplug controllers, pulse one line per status bit. The block drives a level-sensitive system control interrupt (SCI). The interrupt line number advertised to software for this output is 9.

A host access names a start address and a length of 1 to 4 bytes. The block accepts the access in one cycle. It then performs the access as a run of single-byte operations, one per clock, in little-endian order. A done pulse marks the end of the run and carries the collected read data. The SCI level is re-evaluated at every clock edge where a byte write or an event changes the register state.

Top module: `gpe_block`

## Requirements
- R1: After reset every status and enable bit is 0, `sci` is low, and `io_busy` and `io_done` are low.
- R2: Only byte addresses 0xAFE0 to 0xAFE3 are decoded. A byte operation on any other address reads as 0x00 and changes no state. This holds even when that byte is part of a multi-byte access that also touches the window.
- R3: An access is accepted when `io_req` is high and `io_busy` is low. `io_len` equals the byte count minus 1. Byte i of the access goes to address `io_addr`+i and uses data bits [8i+7:8i]. The access takes `io_len`+1 byte cycles, with `io_busy` high throughout. `io_done` is then high for exactly one cycle. A request made while busy is ignored.
- R4: Offsets 0 and 1 are status bytes. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R5: Offsets 2 and 3 are enable bytes. They store the written value directly and read it back. Bit k of offset 2+j enables bit k of status offset j.
- R6: When `evt_in[b]` is high in a cycle, status bit b (offset b/8, bit b%8) is set at the next clock edge. If a status byte write in that same cycle also clears the bit, the event wins and the bit is set.
- R7: `sci` is high exactly when some status bit and its enable bit are both set. It follows a state change at the same clock edge that updates the registers.
- R8: A read leaves all status and enable bits unchanged. On a read, `io_rdata` carries byte i in lane i, and unused lanes are 0. On a write, `io_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Access request |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address of the first byte |
| io_len | input | 2 | Byte count minus 1 |
| io_wdata | input | 32 | Write data, byte i in lane i |
| io_busy | output | 1 | Byte operations in progress |
| io_done | output | 1 | One-cycle end-of-access pulse |
| io_rdata | output | 32 | Collected read data, valid with io_done |
| evt_in | input | 16 | Event set pulses, one per status bit |
| sci | output | 1 | SCI level request |

## Verification
The hardest case to reach from the ports is an event pulse landing in the exact cycle in which a write-1-clear byte operation hits the same status bit. The bench can reach it because the byte operation runs at a known offset from acceptance. The bench therefore raises the event line in the first cycle after the request is accepted, on a single-byte clear, and then reads the bit back. A second hard case is a request issued while a four-byte access is still running. The bench aims that request at an enable byte, then reads the byte back to confirm the request was dropped. A straddling access tests decode: it starts below the window and ends inside it, and it shows that the outside bytes are ignored while the inside bytes still take effect.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int unsigned IO_AW = 16;
  typedef logic [IO_AW-1:0] io_addr_t;

  localparam io_addr_t    GPE_BASE_DEF = 16'hAFE0;
  localparam int unsigned GPE_WIN_DEF  = 4;
  localparam int unsigned SCI_LINE     = 9;

  typedef struct packed {
    logic     wr;
    io_addr_t addr;
    logic [7:0] data;
  } byte_op_t;

  function automatic logic f_hit(io_addr_t a, io_addr_t base, int unsigned win);
    return (a >= base) && ((32'(a) - 32'(base)) < win);
  endfunction

  function automatic logic [31:0] f_off(io_addr_t a, io_addr_t base);
    return 32'(a) - 32'(base);
  endfunction

  function automatic logic [7:0] f_w1c(logic [7:0] cur, logic [7:0] clr);
    return cur & ~clr;
  endfunction
endpackage

// File: rtl/gpe_split.sv
module gpe_split
  import gpe_pkg::*;
#(
  parameter int unsigned WIN = GPE_WIN_DEF,
  localparam int unsigned LW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int unsigned DW = WIN * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  io_addr_t      addr,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          op_valid,
  output byte_op_t      op,
  input  logic [7:0]    rd_byte
);
  logic          busy_q, done_q, wr_q;
  logic [LW-1:0] cnt_q, len_q;
  io_addr_t      addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          accept, last;

  assign accept   = req && !busy_q;
  assign last     = (cnt_q == len_q);
  assign op_valid = busy_q;
  assign op.wr    = wr_q;
  assign op.addr  = addr_q + io_addr_t'(cnt_q);
  assign op.data  = wdata_q[{cnt_q, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        len_q   <= len;
        wr_q    <= wr;
        addr_q  <= addr;
        wdata_q <= wdata;
        rdata_q <= '0;
      end else if (busy_q) begin
        if (!wr_q) rdata_q[{cnt_q, 3'b000} +: 8] <= rd_byte;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;

  // R3: accepted request starts at byte 0
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && cnt_q == '0));
  // R3: final byte ends the run with a done pulse
  p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> (!busy_q && done_q));
  // R3: done lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3: request while busy leaves the latched access alone
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req) |=> ($stable(addr_q) && $stable(len_q) && $stable(wr_q)));
endmodule

// File: rtl/gpe_regs.sv
module gpe_regs
  import gpe_pkg::*;
#(
  parameter io_addr_t    BASE = GPE_BASE_DEF,
  parameter int unsigned WIN  = GPE_WIN_DEF,
  localparam int unsigned HALF = WIN / 2,
  localparam int unsigned NB   = HALF * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  byte_op_t      op,
  input  logic [NB-1:0] evt,
  output logic [7:0]    rd_byte,
  output logic [NB-1:0] sts_q,
  output logic [NB-1:0] en_q,
  output logic [NB-1:0] sts_d,
  output logic [NB-1:0] en_d
);
  logic        hit;
  logic [31:0] off;

  assign hit = op_valid && f_hit(op.addr, BASE, WIN);
  assign off = f_off(op.addr, BASE);

  for (genvar j = 0; j < HALF; j++) begin : g_byte
    logic sel_sts, sel_en;
    assign sel_sts = hit && op.wr && (off == 32'(j));
    assign sel_en  = hit && op.wr && (off == 32'(HALF + j));
    assign sts_d[8*j +: 8] = f_w1c(sts_q[8*j +: 8], sel_sts ? op.data : 8'h00)
                             | evt[8*j +: 8];
    assign en_d[8*j +: 8]  = sel_en ? op.data : en_q[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (hit && !op.wr) begin
      for (int j = 0; j < HALF; j++) begin
        if (off == 32'(j))        rd_byte = sts_q[8*j +: 8];
        if (off == 32'(HALF + j)) rd_byte = en_q[8*j +: 8];
      end
    end
  end

  // R6: an event pulse leaves its status bit set
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));
  // R2: a write outside the window changes nothing
  p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op.wr && !hit && evt == '0) |=> ($stable(sts_q) && $stable(en_q)));
  // R8: reads are side-effect free
  p_read_pure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op.wr && evt == '0) |=> ($stable(sts_q) && $stable(en_q)));
  // R5: enables change only on a decoded write
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && op.wr) |=> $stable(en_q));
endmodule

// File: rtl/gpe_sci.sv
module gpe_sci #(
  parameter int unsigned NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] sts_d,
  input  logic [NB-1:0] en_d,
  input  logic [NB-1:0] sts_q,
  input  logic [NB-1:0] en_q,
  output logic          sci
);
  function automatic logic f_pending(logic [NB-1:0] s, logic [NB-1:0] e);
    return |(s & e);
  endfunction

  logic sci_q;
  always_ff @(posedge clk) begin
    if (!rst_n) sci_q <= 1'b0;
    else        sci_q <= f_pending(sts_d, en_d);
  end
  assign sci = sci_q;

  // R7: the level tracks the stored registers at every edge
  p_sci_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sci_q == (|(sts_q & en_q)));
  // R7: no pending pair means no request
  p_sci_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_d & en_d) == '0) |=> !sci_q);
endmodule

// File: rtl/gpe_block.sv
module gpe_block
  import gpe_pkg::*;
#(
  parameter io_addr_t    BASE = GPE_BASE_DEF,
  parameter int unsigned WIN  = GPE_WIN_DEF,
  localparam int unsigned NB  = (WIN / 2) * 8,
  localparam int unsigned LW  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int unsigned DW  = WIN * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          io_wr,
  input  logic [15:0]   io_addr,
  input  logic [LW-1:0] io_len,
  input  logic [DW-1:0] io_wdata,
  output logic          io_busy,
  output logic          io_done,
  output logic [DW-1:0] io_rdata,
  input  logic [NB-1:0] evt_in,
  output logic          sci
);
  byte_op_t      op;
  logic          op_valid;
  logic [7:0]    rd_byte;
  logic [NB-1:0] sts_q, en_q, sts_d, en_d;

  gpe_split #(.WIN(WIN)) u_split (
    .clk(clk), .rst_n(rst_n), .req(io_req), .wr(io_wr), .addr(io_addr),
    .len(io_len), .wdata(io_wdata), .busy(io_busy), .done(io_done),
    .rdata(io_rdata), .op_valid(op_valid), .op(op), .rd_byte(rd_byte)
  );

  gpe_regs #(.BASE(BASE), .WIN(WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .evt(evt_in),
    .rd_byte(rd_byte), .sts_q(sts_q), .en_q(en_q), .sts_d(sts_d), .en_d(en_d)
  );

  gpe_sci #(.NB(NB)) u_sci (
    .clk(clk), .rst_n(rst_n), .sts_d(sts_d), .en_d(en_d),
    .sts_q(sts_q), .en_q(en_q), .sci(sci)
  );
endmodule

// File: tb/sim_gpe_block.sv
module sim_gpe_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_len = '0;
  logic [31:0] io_wdata = '0;
  logic        io_busy, io_done, sci;
  logic [31:0] io_rdata;
  logic [15:0] evt_in = '0;

  always #5 clk = ~clk;

  gpe_block u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_len(io_len), .io_wdata(io_wdata), .io_busy(io_busy), .io_done(io_done),
    .io_rdata(io_rdata), .evt_in(evt_in), .sci(sci)
  );

  typedef struct { logic [31:0] rd; string tag; } exp_t;
  exp_t q[$];
  logic [7:0] mdl [4];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic mdl_sci();
    return |((mdl[0] & mdl[2]) | (mdl[1] & mdl[3]));
  endfunction

  function automatic logic in_win(logic [15:0] a);
    return a >= 16'hAFE0 && a <= 16'hAFE3;
  endfunction

  // monitor: compare each done against the queued expectation
  always @(negedge clk) begin
    if (rst_n && io_done) begin
      if (q.size() == 0) chk("R3 unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, io_rdata, e.rd);
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input int len,
                        input logic [31:0] wd, input logic [15:0] ev, input string tag);
    exp_t e;
    int k;
    e.rd = '0;
    e.tag = tag;
    for (int i = 0; i <= len; i++) begin
      logic [15:0] ai;
      ai = a + 16'(i);
      if (in_win(ai)) begin
        int off;
        off = int'(ai - 16'hAFE0);
        if (wr) begin
          if (off < 2) mdl[off] = mdl[off] & ~wd[8*i +: 8];
          else         mdl[off] = wd[8*i +: 8];
        end else e.rd[8*i +: 8] = mdl[off];
      end
    end
    mdl[0] = mdl[0] | ev[7:0];
    mdl[1] = mdl[1] | ev[15:8];
    q.push_back(e);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_len = 2'(len); io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    evt_in = ev;
    chk({tag, " R3 busy"}, 32'(io_busy), 32'd1);
    k = 0;
    do begin
      @(negedge clk);
      evt_in = '0;
      k++;
    end while (!io_done && k < 10);
    chk({tag, " R3 byte cycles"}, 32'(k), 32'(len + 1));
    chk({tag, " R7 sci"}, 32'(sci), 32'(mdl_sci()));
  endtask

  task automatic post(input logic [15:0] ev, input string tag);
    @(negedge clk);
    evt_in = ev;
    @(negedge clk);
    evt_in = '0;
    mdl[0] = mdl[0] | ev[7:0];
    mdl[1] = mdl[1] | ev[15:8];
    chk({tag, " R7 sci"}, 32'(sci), 32'(mdl_sci()));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R3 watchdog act=%0d exp=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 sci", 32'(sci), 32'd0);
    chk("R1 busy", 32'(io_busy), 32'd0);
    chk("R1 done", 32'(io_done), 32'd0);
    access(0, 16'hAFE0, 3, 0, 0, "R1 regs zero");

    // R5/R3: enable bytes via 4-byte little-endian write, read back 2 bytes
    access(1, 16'hAFE0, 3, 32'h3CA5_0000, 0, "R5 write en");
    access(0, 16'hAFE2, 1, 0, 0, "R5 en readback");

    // R6/R7: event on enabled bit raises sci
    post(16'h0001, "R6 evt bit0");
    access(0, 16'hAFE0, 0, 0, 0, "R6 status read");
    access(0, 16'hAFE0, 0, 0, 0, "R8 read again");

    // R4: write-1-clear
    access(1, 16'hAFE0, 0, 32'h00, 0, "R4 write zero");
    access(1, 16'hAFE0, 0, 32'hFE, 0, "R4 other bits");
    access(1, 16'hAFE0, 0, 32'h01, 0, "R4 clear bit0");

    // R7: event on disabled bit keeps sci low, enabling it raises sci
    post(16'h0200, "R7 disabled evt");
    access(0, 16'hAFE0, 1, 0, 0, "R6 status byte1");
    access(1, 16'hAFE3, 0, 32'h02, 0, "R7 enable late");
    access(1, 16'hAFE3, 0, 32'h00, 0, "R7 disable");

    // R2: straddling and outside accesses
    access(1, 16'hAFDF, 3, 32'hFFFF_FFFF, 0, "R2 straddle write");
    access(0, 16'hAFE2, 3, 0, 0, "R2 straddle read");
    access(1, 16'h1000, 3, 32'hFFFF_FFFF, 0, "R2 far write");
    access(0, 16'hAFF0, 3, 0, 0, "R2 far read");
    access(0, 16'hAFE0, 3, 0, 0, "R2 window intact");

    // R6: event wins over same-cycle clear
    access(1, 16'hAFE2, 0, 32'h08, 0, "R5 en bit3");
    access(1, 16'hAFE0, 0, 32'h08, 16'h0008, "R6 evt beats clear");
    access(0, 16'hAFE0, 0, 0, 0, "R6 bit kept");
    access(1, 16'hAFE0, 0, 32'h08, 0, "R4 plain clear");

    // R3: request during busy is dropped
    begin
      exp_t e;
      e.rd = {mdl[3], mdl[2], mdl[1], mdl[0]};
      e.tag = "R3 busy read";
      q.push_back(e);
      @(negedge clk);
      io_req = 1'b1; io_wr = 1'b0; io_addr = 16'hAFE0; io_len = 2'd3;
      @(negedge clk);
      io_req = 1'b0;
      @(negedge clk);
      chk("R3 busy mid", 32'(io_busy), 32'd1);
      io_req = 1'b1; io_wr = 1'b1; io_addr = 16'hAFE2; io_len = 2'd0; io_wdata = 32'hFF;
      @(negedge clk);
      io_req = 1'b0;
      while (!io_done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R3 no extra access", 32'(io_busy), 32'd0);
    end
    access(0, 16'hAFE2, 0, 0, 0, "R3 ignored req");

    // R1: reset after activity
    post(16'h0008, "R1 pre-reset evt");
    do_reset();
    chk("R1 sci after reset", 32'(sci), 32'd0);
    access(0, 16'hAFE0, 3, 0, 0, "R1 regs cleared");

    repeat (3) @(negedge clk);
    chk("R3 queue drained", 32'(q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule